// File: doc/BRIEF.md
# Addressable Latch Output Driver

This block drives eight on/off loads such as relays, lamps or LED digits from a narrow control interface. A 3-bit select value names one of the eight outputs and a single data bit says whether that output should be on or off. An active-low enable and an active-low clear combine into four operating modes:

- **Write**: the selected output is loaded.
- **Hold**: nothing changes.
- **Clear**: everything is switched off.
- **Demultiplex**: only the selected output follows the data bit and all others are off.

The storage elements are clocked registers rather than transparent latches. Every control input is sampled on the rising edge of the system clock, and the new output state appears after that edge. Two output vectors are provided. One is an active-low drive vector for the load switches. The other is an active-high status vector, in which bit n reads 1 while output n is on. A synchronous active-high reset gives the power-up clear.

The mode is decoded from the two control pins by `drv_mode_dec` into four named modes:

| Mode | `clr_n` | `en_n` |
|---|---|---|
| MD_WRITE | 1 | 0 |
| MD_HOLD | 1 | 1 |
| MD_CLEAR | 0 | 1 |
| MD_DEMUX | 0 | 0 |

On each clock edge, `drv_latch_bank` moves its state vector according to the mode (unique case):

- MD_WRITE: merge the data bit into the selected bit.
- MD_HOLD: keep the state.
- MD_CLEAR: go to all zero.
- MD_DEMUX: load the one-hot select vector ANDed with the data bit.

Reset takes the state vector to all zero from any mode.

Top module: `addr_latch_drv`

## Requirements
- R1: While `rst` is high at a rising edge, every output is off after that edge (`on_stat` = 0, `drive_n` all ones), whatever the other inputs are.
- R2: `drive_n` is always the bitwise inverse of `on_stat`: an output that is on drives 0, one that is off drives 1.
- R3: With `clr_n`=1 and `en_n`=0 at an edge, status bit `sel_addr` equals `din` after that edge (1 = on, 0 = off).
- R4: In the write mode of R3, the seven unselected status bits keep their previous values.
- R5: With `clr_n`=1 and `en_n`=1 at an edge, all status bits keep their previous values, whatever `sel_addr` and `din` are.
- R6: With `clr_n`=0 and `en_n`=1 at an edge, all status bits are 0 after that edge.
- R7: With `clr_n`=0 and `en_n`=0 at an edge, the status vector becomes `din` shifted left by `sel_addr`: exactly one bit on when `din`=1, none when `din`=0.
- R8: Select value k addresses status bit k and drive bit k, with bit 0 the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-up clear |
| sel_addr | input | ADDR_W (3) | Index of the output to load |
| din | input | 1 | Data bit: 1 turns the output on, 0 turns it off |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| drive_n | output | 2**ADDR_W (8) | Active-low load drive, one bit per output |
| on_stat | output | 2**ADDR_W (8) | Active-high on status, one bit per output |

## Verification
Every result is due one cycle after its stimulus. Inputs presented before a rising edge are reflected on both output vectors just after that edge, and this applies to reset as well as to the four modes. The bench changes inputs on the falling edge and waits exactly one rising edge. It then compares both vectors at the next falling edge against a bench model that applies the mode rule to its previous state. Every mode, select value and data value is swept from several preloaded patterns, so hold, write and demultiplex are each seen acting on mixed on/off states.

// File: rtl/drv_pkg.sv
package drv_pkg;
    // Mode encoding is {clr_n, en_n}
    typedef enum logic [1:0] {
        MD_DEMUX = 2'b00,
        MD_CLEAR = 2'b01,
        MD_WRITE = 2'b10,
        MD_HOLD  = 2'b11
    } mode_e;
endpackage

// File: rtl/drv_mode_dec.sv
module drv_mode_dec
    import drv_pkg::*;
(
    input  logic  clr_n,
    input  logic  en_n,
    output mode_e mode
);
    always_comb begin
        unique case ({clr_n, en_n})
            2'b00:   mode = MD_DEMUX;
            2'b01:   mode = MD_CLEAR;
            2'b10:   mode = MD_WRITE;
            default: mode = MD_HOLD;
        endcase
    end
endmodule

// File: rtl/drv_sel_dec.sv
module drv_sel_dec #(
    parameter int ADDR_W = 3,
    localparam int NUM_OUT = 2 ** ADDR_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_OUT-1:0] sel
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_sel
        assign sel[g] = (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/drv_latch_bank.sv
module drv_latch_bank
    import drv_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  mode_e              mode,
    input  logic [NUM_OUT-1:0] sel,
    input  logic               din,
    output logic [NUM_OUT-1:0] lat
);
    logic [NUM_OUT-1:0] din_vec;
    assign din_vec = {NUM_OUT{din}};

    // State register: next state chosen by the decoded mode
    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else begin
            unique case (mode)
                MD_WRITE: lat <= (lat & ~sel) | (sel & din_vec);
                MD_HOLD:  lat <= lat;
                MD_CLEAR: lat <= '0;
                MD_DEMUX: lat <= sel & din_vec;
            endcase
        end
    end

    // R1
    reset_off_chk: assert property (@(posedge clk) rst |=> (lat == '0));

    // R3
    write_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_WRITE) |=> ((lat & $past(sel)) == ($past(sel) & {NUM_OUT{$past(din)}})));

    // R4
    write_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_WRITE) |=> ((lat & ~$past(sel)) == ($past(lat) & ~$past(sel))));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_HOLD) |=> $stable(lat));

    // R6
    clear_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_CLEAR) |=> (lat == '0));

    // R7
    demux_one_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_DEMUX) |=> ($onehot0(lat) && ($countones(lat) == int'($past(din)))));
endmodule

// File: rtl/addr_latch_drv.sv
module addr_latch_drv
    import drv_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NUM_OUT = 2 ** ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  sel_addr,
    input  logic               din,
    input  logic               en_n,
    input  logic               clr_n,
    output logic [NUM_OUT-1:0] drive_n,
    output logic [NUM_OUT-1:0] on_stat
);
    mode_e              mode;
    logic [NUM_OUT-1:0] sel;
    logic [NUM_OUT-1:0] lat;

    drv_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    drv_sel_dec #(.ADDR_W(ADDR_W)) u_sel (
        .addr (sel_addr),
        .sel  (sel)
    );

    drv_latch_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .sel  (sel),
        .din  (din),
        .lat  (lat)
    );

    // Output process: status and active-low drive
    always_comb begin
        on_stat = lat;
        drive_n = ~lat;
    end

    // R8
    sel_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_DEMUX && din) |=> on_stat[$past(sel_addr)]);
endmodule

// File: tb/tb_addr_latch_drv.sv
`timescale 1ns/1ps
module tb_addr_latch_drv;
    localparam int AW = 3;
    localparam int N  = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] a = '0;
    logic          d = 1'b0;
    logic          en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [N-1:0]  drive_n, on_stat;
    logic [N-1:0]  model = '0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    addr_latch_drv #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sel_addr(a), .din(d),
        .en_n(en_n), .clr_n(clr_n), .drive_n(drive_n), .on_stat(on_stat)
    );

    task automatic check(string tag, logic [N-1:0] exp);
        checks++;
        if (on_stat !== exp) begin
            errors++;
            $display("FAIL %s on_stat actual=%b expected=%b", tag, on_stat, exp);
        end
        checks++;
        if (drive_n !== ~exp) begin
            errors++;
            $display("FAIL R2 (%s) drive_n actual=%b expected=%b", tag, drive_n, ~exp);
        end
    endtask

    // Called at a falling edge; applies one edge and checks at the next falling edge
    task automatic step(logic c, logic e, logic [AW-1:0] ad, logic dv);
        string tag;
        clr_n = c; en_n = e; a = ad; d = dv;
        @(posedge clk);
        case ({c, e})
            2'b10: begin model[ad] = dv; tag = "R3 R4 write"; end
            2'b11: tag = "R5 hold";
            2'b01: begin model = '0; tag = "R6 clear"; end
            default: begin model = '0; model[ad] = dv; tag = "R7 demux"; end
        endcase
        @(negedge clk);
        check(tag, model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h81;

        // R1: reset state with write inputs present
        clr_n = 1'b1; en_n = 1'b0; d = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0);
        rst = 1'b0;

        // R8: select k reaches bit k
        for (int k = 0; k < N; k++) begin
            step(1'b0, 1'b1, '0, 1'b0);
            clr_n = 1'b1; en_n = 1'b0; a = AW'(k); d = 1'b1;
            @(posedge clk);
            model = '0; model[k] = 1'b1;
            @(negedge clk);
            check("R8 select map", N'(1) << k);
        end

        // Sweep all modes, selects and data from several preloaded patterns
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < N; i++) step(1'b1, 1'b0, AW'(i), pats[p][i]);
            for (int m = 0; m < 4; m++) begin
                for (int ad = 0; ad < N; ad++) begin
                    for (int dv = 0; dv < 2; dv++) begin
                        case (m)
                            0: step(1'b1, 1'b1, AW'(ad), dv[0]);
                            1: step(1'b1, 1'b0, AW'(ad), dv[0]);
                            2: step(1'b0, 1'b0, AW'(ad), dv[0]);
                            default: step(1'b0, 1'b1, AW'(ad), dv[0]);
                        endcase
                    end
                end
            end
        end

        // R1: reset mid-run overrides a write of 1
        for (int i = 0; i < N; i++) step(1'b1, 1'b0, AW'(i), 1'b1);
        rst = 1'b1; clr_n = 1'b1; en_n = 1'b0; a = 3'd5; d = 1'b1;
        @(posedge clk);
        model = '0;
        @(negedge clk);
        check("R1 reset mid-run", '0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule